// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits in the transmit path of a CAN transceiver, between the transmit-data line from the protocol controller and the enable of the bus driver. A low transmit input asks for a dominant bus. A high input asks for recessive. The block raises a single driver-dominant command only when that request is safe to honour.

Three conditions force the bus recessive. The first is a low held for longer than the permitted dominant window. The second is an over-temperature flag. The third is the standby mode. Both fault disables are sticky. Clearing the fault condition does not release the driver. The driver comes back only after the transmit input has been seen high for at least one clock. The transmit input, the over-temperature flag and the standby request are all asynchronous, so each is brought into the clock domain through the same synchronizer depth. All three therefore reach the output with the same latency.

Top module: `txd_dom_guard`

## Requirements
- R1: In normal mode with no thermal fault, `drvDominant` is 1 while the synchronized transmit input is 0 and is 0 while it is 1. A low transmit input means dominant.
- R2: A change on `txdIn`, `overTemp` or `standbyReq` applied between clock edges first shows on `drvDominant` right after the SYNC_STAGES-th rising edge that follows it.
- R3: While the transmit input stays low without a break, `drvDominant` is 1 for exactly TIMEOUT_CYCLES clock cycles and is then 0 for the rest of that low run.
- R4: After a timeout, the output stays recessive until the transmit input is high for at least one cycle. The next low run then gets a full new window.
- R5: A low run of TIMEOUT_CYCLES cycles or fewer never trips the timeout. A single high cycle between runs is enough to restart the window.
- R6: While `overTemp` (after synchronization) is 1, `drvDominant` is 0.
- R7: A thermal disable stays in force after `overTemp` drops, for as long as the transmit input stays low. It clears only after a cycle in which the transmit input is high and `overTemp` is 0.
- R8: While `standbyReq` (after synchronization) is 1, `drvDominant` is 0. The dominant timer keeps counting during standby. A low run that began in standby is still timed from its own start.
- R9: During and after reset the transmit input is treated as high and no thermal disable is held. `drvDominant` is therefore 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txdIn | input | 1 | Transmit data from the controller; 0 = dominant request |
| overTemp | input | 1 | Over-temperature flag from the thermal sensor; 1 = too hot |
| standbyReq | input | 1 | Mode select; 1 = standby, 0 = normal |
| drvDominant | output | 1 | Command to the bus driver; 1 = drive dominant |

## Verification
The timeout is probed with three kinds of low runs. Alternating single bits show the plain inversion and the latency. Runs of exactly the window length with one high cycle between them must never trip, which separates an off-by-one window from a correct one. Overlong runs must cut off at the exact cycle and stay cut off until a high cycle arrives. The thermal flag is pulsed in the middle of a low run and then dropped, to show the disable is latched rather than following the flag. It is also dropped while the input is high, to show the release path. Standby is raised across the start of a low run and released after the window has already elapsed, which shows that the timer kept running.

// File: rtl/txd_dom_guard_pkg.sv
package txd_dom_guard_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic otSet;
    logic otClear;
  } txgStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic txdLow;
    logic otFlag;
    logic stby;
    logic expired;
    logic otHeld;
  } txgStatus_t;

  // Synchronizer lane order: {standby, overTemp, txd}
  localparam int LANES = 3;
  localparam logic [LANES-1:0] SYNC_RST = 3'b101;

endpackage

// File: rtl/txd_dom_guard_dp.sv
module txd_dom_guard_dp
  import txd_dom_guard_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 65000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txdIn,
  input  logic       overTemp,
  input  logic       standbyReq,
  input  txgStrobe_t strobe,
  output txgStatus_t status
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYCLES);
  localparam int CHAIN_W = SYNC_STAGES * LANES;

  logic [LANES-1:0] rawIn;
  logic [CHAIN_W-1:0] stage;
  logic [CHAIN_W+LANES-1:0] chain;
  logic [LANES-1:0] syncOut;
  logic [CNT_W-1:0] lowCount;
  logic otHeld;

  assign rawIn   = {standbyReq, overTemp, txdIn};
  assign chain   = {stage, rawIn};
  assign syncOut = stage[CHAIN_W-1 -: LANES];

  // Equal-depth synchronizers for all three inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= {SYNC_STAGES{SYNC_RST}};
    else       stage <= chain[CHAIN_W-1:0];
  end

  // Dominant-run counter, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCount <= '0;
    else if (strobe.cntClear) lowCount <= '0;
    else if (strobe.cntStep)  lowCount <= lowCount + 1'b1;
  end

  // Sticky thermal disable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               otHeld <= 1'b0;
    else if (strobe.otSet)   otHeld <= 1'b1;
    else if (strobe.otClear) otHeld <= 1'b0;
  end

  assign status.txdLow  = ~syncOut[0];
  assign status.otFlag  = syncOut[1];
  assign status.stby    = syncOut[2];
  assign status.expired = (lowCount == LIMIT);
  assign status.otHeld  = otHeld;

endmodule

// File: rtl/txd_dom_guard_ctl.sv
module txd_dom_guard_ctl
  import txd_dom_guard_pkg::*;
(
  input  txgStatus_t status,
  output txgStrobe_t strobe,
  output logic       drvDominant
);
  always_comb begin
    strobe.cntClear = ~status.txdLow;
    strobe.cntStep  = status.txdLow & ~status.expired;
    strobe.otSet    = status.otFlag;
    strobe.otClear  = ~status.txdLow & ~status.otFlag;
  end

  assign drvDominant = status.txdLow & ~status.expired & ~status.otFlag
                     & ~status.otHeld & ~status.stby;

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
  import txd_dom_guard_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 65000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic overTemp,
  input  logic standbyReq,
  output logic drvDominant
);
  txgStrobe_t strobe;
  txgStatus_t status;
  logic txdSync;
  logic otSync;
  logic stbySync;

  txd_dom_guard_dp #(
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .SYNC_STAGES   (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .txdIn     (txdIn),
    .overTemp  (overTemp),
    .standbyReq(standbyReq),
    .strobe    (strobe),
    .status    (status)
  );

  txd_dom_guard_ctl u_ctl (
    .status     (status),
    .strobe     (strobe),
    .drvDominant(drvDominant)
  );

  assign txdSync  = ~status.txdLow;
  assign otSync   = status.otFlag;
  assign stbySync = status.stby;

endmodule

// File: rtl/txd_dom_guard_chk.sv
module txd_dom_guard_chk #(
  parameter int TIMEOUT_CYCLES = 65000
) (
  input logic clk,
  input logic rstN,
  input logic txdSync,
  input logic otSync,
  input logic stbySync,
  input logic drvDominant
);
  // Cycles of low already seen before the current one, saturating
  int unsigned lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        lowRun <= 0;
    else if (txdSync)                 lowRun <= 0;
    else if (lowRun < TIMEOUT_CYCLES) lowRun <= lowRun + 1;
  end

  p_recessive_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    txdSync |-> !drvDominant);

  p_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    drvDominant |-> (lowRun < TIMEOUT_CYCLES));

  p_relaunch_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(txdSync) && !$past(otSync) && !txdSync && !otSync && !stbySync) |-> drvDominant);

  p_ot_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    otSync |-> !drvDominant);

  p_ot_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!txdSync && $past(otSync && !txdSync)) |-> !drvDominant);

  p_stby_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    stbySync |-> !drvDominant);

endmodule

bind txd_dom_guard txd_dom_guard_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .txdSync    (txdSync),
  .otSync     (otSync),
  .stbySync   (stbySync),
  .drvDominant(drvDominant)
);

// File: tb/tb_txd_dom_guard.sv
module tb_txd_dom_guard;
  localparam int T = 12;
  localparam int L = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdIn = 1'b1;
  logic overTemp = 1'b0;
  logic standbyReq = 1'b0;
  logic drvDominant;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  // scoreboard queues
  int    dueQ[$];
  bit    expQ[$];
  string tagQ[$];

  // reference state derived from the requirements
  int lowRun = 0;
  bit otHold = 0;

  txd_dom_guard #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(L)) dut (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .overTemp(overTemp),
    .standbyReq(standbyReq), .drvDominant(drvDominant)
  );

  always #5 clk = ~clk;

  // monitor: compare once the latency has elapsed
  always @(posedge clk) begin
    cyc = cyc + 1;
    #2;
    while (dueQ.size() > 0 && dueQ[0] <= cyc) begin
      total++;
      if (drvDominant !== expQ[0]) begin
        bad++;
        $display("FAIL %s cycle %0d: drvDominant=%0b expected=%0b", tagQ[0], cyc, drvDominant, expQ[0]);
      end
      void'(dueQ.pop_front());
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
    end
  end

  // driver: apply one cycle of inputs and push the expected output
  task automatic step(input bit txd, input bit ot, input bit stby, input string tag);
    bit e;
    @(negedge clk);
    txdIn = txd; overTemp = ot; standbyReq = stby;
    lowRun = txd ? 0 : lowRun + 1;
    e = !txd && (lowRun <= T) && !ot && !otHold && !stby;
    if (ot) otHold = 1;
    else if (txd) otHold = 0;
    dueQ.push_back(cyc + L);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic run(input bit txd, input int n, input bit ot, input bit stby, input string tag);
    for (int i = 0; i < n; i++) step(txd, ot, stby, tag);
  endtask

  initial begin
    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (drvDominant !== 1'b0) begin
      bad++; $display("FAIL R9 in reset: drvDominant=%0b expected=0", drvDominant);
    end
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (drvDominant !== 1'b0) begin
      bad++; $display("FAIL R9 after reset: drvDominant=%0b expected=0", drvDominant);
    end

    // R1 / R2: alternating bits, each edge checked at its exact cycle
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R2");
    step(1, 0, 0, "R2");
    step(0, 0, 0, "R1");
    step(0, 0, 0, "R1");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R1");
    step(1, 0, 0, "R1");
    run(1, 3, 0, 0, "R1");

    // R3: overlong low run cuts off after exactly T cycles
    run(0, T + 8, 0, 0, "R3");
    // R4: stays recessive until a high cycle, then full window again
    run(0, 4, 0, 0, "R4");
    step(1, 0, 0, "R4");
    run(0, T + 3, 0, 0, "R4");
    run(1, 2, 0, 0, "R4");

    // R5: runs of exactly T and T-1 separated by one high cycle
    for (int k = 0; k < 3; k++) begin
      run(0, T, 0, 0, "R5");
      step(1, 0, 0, "R5");
    end
    run(0, T - 1, 0, 0, "R5");
    step(1, 0, 0, "R5");
    run(0, 1, 0, 0, "R5");
    run(1, 2, 0, 0, "R5");

    // R6: over-temperature during a low run
    run(0, 3, 0, 0, "R6");
    run(0, 2, 1, 0, "R6");
    // R7: flag gone but still low -> stays off
    run(0, 5, 0, 0, "R7");
    step(1, 0, 0, "R7");
    run(0, 3, 0, 0, "R7");
    // R7: flag dropped while high, high cycle with flag low releases
    step(1, 1, 0, "R7");
    step(1, 0, 0, "R7");
    run(0, 2, 0, 0, "R7");
    // R7: flag still high during the high cycle does not release
    step(1, 1, 0, "R7");
    run(0, 2, 0, 0, "R7");
    step(1, 0, 0, "R7");
    run(0, 2, 0, 0, "R7");
    run(1, 2, 0, 0, "R7");

    // R8: standby forces recessive, timer keeps running
    run(0, 3, 0, 1, "R8");
    run(0, 2, 0, 0, "R8");
    run(0, T, 0, 1, "R8");
    run(0, 3, 0, 0, "R8");
    step(1, 0, 1, "R8");
    run(0, 2, 0, 1, "R8");
    run(0, 2, 0, 0, "R8");

    run(1, L + 3, 0, 0, "R1");
    while (dueQ.size() > 0) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule